// File: doc/BRIEF.md
# Disable Tone Detection Controller

This block decides, for one channel, when an answer-tone that should disable echo cancellation is present, and when that condition has ended. An upstream front end supplies, for the receive path and for the send path separately, a per-sample flag saying a 2100 Hz tone is present, a level code for that tone, a one-cycle pulse for each 180 degree phase reversal, and a quiet flag meaning both band-limited energy thresholds (390–700 Hz below -30 dBm0 and 700–3400 Hz below -34 dBm0) are met. A one-cycle tick input marks each millisecond, and every duration is measured in ticks.

Two detector instances, one per path, each time the tone duration and the spacing of reversals. Their results are combined into one status bit. Once the bit is set it stays set until both paths have been quiet for a sustained period, whatever the tone does. A standard-select input chooses between a simple duration rule and a stricter rule that also needs a phase reversal. Every change of the status bit raises an active-low interrupt that is held until software reads the status.

All inputs are plain level or pulse signals sampled on every clock. There is no data stream and no handshake, so there is no back-pressure: the block never stalls its source and never drops a flag.

Top module: `dtone_ctrl`

## Requirements
- R1: A path's tone counts as qualified only while its tone flag is 1 and its level code lies in the accepted window. The level code is the tone level in dB below 0 dBm0. With std_sel=0 the window is codes 6 to 31. With std_sel=1 it is codes 0 to 31.
- R2: With std_sel=1, status rises once one path's tone has been qualified for DET_PLAIN_MS consecutive ticks. Phase reversals make no difference in this mode.
- R3: With std_sel=0, status rises once one path's tone has been qualified for DET_REV_MS consecutive ticks and that path has seen at least one reversal pulse during the same qualified stretch. If the reversal comes after the duration is met, detection follows it.
- R4: Any cycle in which a path's tone is not qualified resets that path's duration count. It also discards any reversal that path has remembered.
- R5: Reversal spacing is measured in ticks since the previous reversal within the same qualified stretch. With std_sel=0, a spacing outside GAP_MIN_MS to GAP_MAX_MS blocks detection on that path until its tone is lost. A spacing inside the window keeps detection possible.
- R6: A reversal pulse that arrives while the path's tone is not qualified is ignored.
- R7: Status rises when either the receive path or the send path meets its detect rule.
- R8: Once high, status stays high when the tone goes away. It falls only after rx_quiet and tx_quiet have both been 1 for QUIET_MS consecutive ticks. Any break in quiet restarts that count.
- R9: irq_n goes low in the cycle after each change of status, in either direction. It stays low until a status_rd strobe. A status change in the same cycle as the strobe keeps irq_n low.
- R10: Time advances only on tick_ms. Duration counters saturate instead of wrapping, so a tone held longer than the counter range is still detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| std_sel | input | 1 | 0: reversal-checking rules, 1: plain duration rules |
| rx_tone | input | 1 | Receive path: tone present |
| rx_level | input | LVL_W | Receive path: tone level code, dB below 0 dBm0 |
| rx_rev | input | 1 | Receive path: phase reversal pulse |
| rx_quiet | input | 1 | Receive path: both band energy thresholds met |
| tx_tone | input | 1 | Send path: tone present |
| tx_level | input | LVL_W | Send path: tone level code, dB below 0 dBm0 |
| tx_rev | input | 1 | Send path: phase reversal pulse |
| tx_quiet | input | 1 | Send path: both band energy thresholds met |
| status_rd | input | 1 | Status read strobe; clears the pending interrupt |
| tone_status | output | 1 | Disable tone detected |
| irq_n | output | 1 | Active-low interrupt on status change |

## Verification
The bench builds the block with LVL_W=6, DET_REV_MS=12, DET_PLAIN_MS=5, a reversal window of 4 to 6 ticks and QUIET_MS=5. With these values every one of the 64 level codes can be swept in both standards. Every reversal spacing from 1 to 9 ticks can be tried against the window. The 4-bit duration counter can be driven past its range within a few dozen ticks, which shows that it saturates rather than wraps.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
  typedef enum logic {
    STD_REVERSAL = 1'b0,
    STD_PLAIN    = 1'b1
  } std_mode_e;

  localparam int unsigned NPATH   = 2;
  localparam int unsigned PATH_RX = 0;
  localparam int unsigned PATH_TX = 1;
endpackage

// File: rtl/dtd_level_gate.sv
module dtd_level_gate #(
  parameter int unsigned LVL_W     = 6,
  parameter int unsigned MIN_REV   = 6,
  parameter int unsigned MIN_PLAIN = 0,
  parameter int unsigned LVL_MAX   = 31
) (
  input  dtd_pkg::std_mode_e mode,
  input  logic               present,
  input  logic [LVL_W-1:0]   level,
  output logic               qualified
);
  logic [LVL_W-1:0] lo_bound;

  always_comb begin
    lo_bound  = (mode == dtd_pkg::STD_PLAIN) ? LVL_W'(MIN_PLAIN) : LVL_W'(MIN_REV);
    qualified = present && (level >= lo_bound) && (level <= LVL_W'(LVL_MAX));
  end
endmodule

// File: rtl/dtd_path.sv
module dtd_path #(
  parameter int unsigned DET_REV_MS   = 1000,
  parameter int unsigned DET_PLAIN_MS = 400,
  parameter int unsigned GAP_MIN_MS   = 425,
  parameter int unsigned GAP_MAX_MS   = 475
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  dtd_pkg::std_mode_e mode,
  input  logic               tone_ok,
  input  logic               rev_pulse,
  output logic               hit
);
  localparam int unsigned DUR_MAX = (DET_REV_MS > DET_PLAIN_MS) ? DET_REV_MS : DET_PLAIN_MS;
  localparam int unsigned DUR_W   = $clog2(DUR_MAX + 1);
  localparam int unsigned GAP_W   = $clog2(GAP_MAX_MS + 2);
  localparam logic [DUR_W-1:0] DUR_TOP = '1;
  localparam logic [GAP_W-1:0] GAP_TOP = '1;

  logic [DUR_W-1:0] dur;
  logic [GAP_W-1:0] gap;
  logic             rev_seen;
  logic             rev_fault;
  logic             gap_bad;

  // duration of the current qualified stretch, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      dur <= '0;
    else if (!tone_ok)               dur <= '0;
    else if (tick && dur != DUR_TOP) dur <= dur + 1'b1;
  end

  assign gap_bad = (gap < GAP_W'(GAP_MIN_MS)) || (gap > GAP_W'(GAP_MAX_MS));

  // reversal memory and spacing check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '0;
      rev_seen  <= 1'b0;
      rev_fault <= 1'b0;
    end else if (!tone_ok) begin
      gap       <= '0;
      rev_seen  <= 1'b0;
      rev_fault <= 1'b0;
    end else if (rev_pulse) begin
      gap      <= '0;
      rev_seen <= 1'b1;
      if (rev_seen && gap_bad) rev_fault <= 1'b1;
    end else if (tick && gap != GAP_TOP) begin
      gap <= gap + 1'b1;
    end
  end

  always_comb begin
    if (mode == dtd_pkg::STD_PLAIN)
      hit = dur >= DUR_W'(DET_PLAIN_MS);
    else
      hit = (dur >= DUR_W'(DET_REV_MS)) && rev_seen && !rev_fault;
  end

  a_r4_drop_clears_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_ok |=> !hit);
  a_r6_no_rev_without_tone: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_ok |=> !rev_seen);
  a_r10_dur_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_ok && dur == DUR_TOP) |=> (dur == DUR_TOP));
  a_r10_dur_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (dur == $past(dur) || dur == '0));
endmodule

// File: rtl/dtd_release.sv
module dtd_release #(
  parameter int unsigned QUIET_MS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic quiet_all,
  output logic done
);
  localparam int unsigned Q_W = $clog2(QUIET_MS + 1);
  localparam logic [Q_W-1:0] Q_TOP = '1;

  logic [Q_W-1:0] qcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       qcnt <= '0;
    else if (!armed || !quiet_all)    qcnt <= '0;
    else if (tick && qcnt != Q_TOP)   qcnt <= qcnt + 1'b1;
  end

  assign done = armed && (qcnt >= Q_W'(QUIET_MS));

  a_r8_break_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet_all |=> (qcnt == '0));
  a_r8_count_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && qcnt != '0) |=> (qcnt == $past(qcnt) || qcnt == '0));
endmodule

// File: rtl/dtone_ctrl.sv
module dtone_ctrl #(
  parameter int unsigned LVL_W        = 6,
  parameter int unsigned LVL_MIN_REV  = 6,
  parameter int unsigned LVL_MIN_PLN  = 0,
  parameter int unsigned LVL_MAX      = 31,
  parameter int unsigned DET_REV_MS   = 1000,
  parameter int unsigned DET_PLAIN_MS = 400,
  parameter int unsigned GAP_MIN_MS   = 425,
  parameter int unsigned GAP_MAX_MS   = 475,
  parameter int unsigned QUIET_MS     = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             std_sel,
  input  logic             rx_tone,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_rev,
  input  logic             rx_quiet,
  input  logic             tx_tone,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_rev,
  input  logic             tx_quiet,
  input  logic             status_rd,
  output logic             tone_status,
  output logic             irq_n
);
  import dtd_pkg::*;

  std_mode_e        mode;
  logic [NPATH-1:0] p_tone, p_rev, p_ok, p_hit;
  logic [LVL_W-1:0] p_lvl [NPATH];
  logic             quiet_all;
  logic             rel_done;
  logic             status_q, status_d, change;
  logic             irq_pend;

  assign mode           = std_mode_e'(std_sel);
  assign p_tone         = {tx_tone, rx_tone};
  assign p_rev          = {tx_rev, rx_rev};
  assign p_lvl[PATH_RX] = rx_level;
  assign p_lvl[PATH_TX] = tx_level;
  assign quiet_all      = rx_quiet && tx_quiet;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    dtd_level_gate #(
      .LVL_W    (LVL_W),
      .MIN_REV  (LVL_MIN_REV),
      .MIN_PLAIN(LVL_MIN_PLN),
      .LVL_MAX  (LVL_MAX)
    ) u_gate (
      .mode     (mode),
      .present  (p_tone[g]),
      .level    (p_lvl[g]),
      .qualified(p_ok[g])
    );

    dtd_path #(
      .DET_REV_MS  (DET_REV_MS),
      .DET_PLAIN_MS(DET_PLAIN_MS),
      .GAP_MIN_MS  (GAP_MIN_MS),
      .GAP_MAX_MS  (GAP_MAX_MS)
    ) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_ms),
      .mode     (mode),
      .tone_ok  (p_ok[g]),
      .rev_pulse(p_rev[g]),
      .hit      (p_hit[g])
    );
  end

  dtd_release #(.QUIET_MS(QUIET_MS)) u_release (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_ms),
    .armed    (status_q),
    .quiet_all(quiet_all),
    .done     (rel_done)
  );

  // latched status: set by any path, cleared only by sustained quiet
  always_comb begin
    status_d = status_q;
    if (!status_q && |p_hit)     status_d = 1'b1;
    else if (status_q && rel_done) status_d = 1'b0;
  end
  assign change = status_d != status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_pend <= change || (irq_pend && !status_rd);
    end
  end

  assign tone_status = status_q;
  assign irq_n       = !irq_pend;

  a_r7_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_status) |-> $past(|p_hit));
  a_r8_fall_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tone_status) |-> $past(rx_quiet && tx_quiet));
  a_r9_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_status != $past(tone_status)) |-> !irq_n);
  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !status_rd) |=> !irq_n);
endmodule

// File: tb/dtone_ctrl_tb.sv
module dtone_ctrl_tb;
  localparam int unsigned LVL_W   = 6;
  localparam int unsigned DET_REV = 12;
  localparam int unsigned DET_PLN = 5;
  localparam int unsigned GAP_MIN = 4;
  localparam int unsigned GAP_MAX = 6;
  localparam int unsigned QUIET   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, std_sel = 1'b1, status_rd = 1'b0;
  logic rx_tone = 1'b0, rx_rev = 1'b0, rx_quiet = 1'b0;
  logic tx_tone = 1'b0, tx_rev = 1'b0, tx_quiet = 1'b0;
  logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
  logic tone_status, irq_n;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2ns clk = ~clk;

  dtone_ctrl #(
    .LVL_W(LVL_W), .LVL_MIN_REV(6), .LVL_MIN_PLN(0), .LVL_MAX(31),
    .DET_REV_MS(DET_REV), .DET_PLAIN_MS(DET_PLN),
    .GAP_MIN_MS(GAP_MIN), .GAP_MAX_MS(GAP_MAX), .QUIET_MS(QUIET)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .std_sel(std_sel),
    .rx_tone(rx_tone), .rx_level(rx_level), .rx_rev(rx_rev), .rx_quiet(rx_quiet),
    .tx_tone(tx_tone), .tx_level(tx_level), .tx_rev(tx_rev), .tx_quiet(tx_quiet),
    .status_rd(status_rd), .tone_status(tone_status), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    tick_ms = 1'b1; @(negedge clk);
    tick_ms = 1'b0; @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rx_rev_pulse();
    rx_rev = 1'b1; @(negedge clk); rx_rev = 1'b0; @(negedge clk);
  endtask

  task automatic rd();
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0; @(negedge clk);
  endtask

  task automatic release_all();
    rx_tone = 1'b0; tx_tone = 1'b0; step(1);
    rx_quiet = 1'b1; tx_quiet = 1'b1;
    ticks(QUIET);
    rx_quiet = 1'b0; tx_quiet = 1'b0;
    rd();
    chk("R8 cleanup", tone_status, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R9 reset irq", irq_n, 1'b1);
    chk("R8 reset status", tone_status, 1'b0);

    // R1 sweep of level codes in both standards (R2, R3 detect paths)
    for (int m = 0; m < 2; m++) begin
      for (int code = 0; code < 64; code++) begin
        std_sel = m[0]; rx_level = code[LVL_W-1:0]; rx_tone = 1'b1;
        step(1);
        rx_rev_pulse();
        ticks(m == 1 ? DET_PLN : DET_REV);
        chk("R1 level window", tone_status,
            (code >= (m == 1 ? 0 : 6)) && (code <= 31));
        release_all();
      end
    end

    // R2 threshold in plain mode
    std_sel = 1'b1; rx_level = 6'd10; rx_tone = 1'b1;
    ticks(DET_PLN - 1);
    chk("R2 before threshold", tone_status, 1'b0);
    tick();
    chk("R2 at threshold", tone_status, 1'b1);
    chk("R9 irq on rise", irq_n, 1'b0);
    step(4);
    chk("R9 irq held", irq_n, 1'b0);
    rd();
    chk("R9 irq cleared by read", irq_n, 1'b1);
    release_all();

    // R3 needs reversal; late reversal triggers
    std_sel = 1'b0; rx_tone = 1'b1;
    ticks(DET_REV + 3);
    chk("R3 no reversal", tone_status, 1'b0);
    rx_rev_pulse();
    chk("R3 late reversal", tone_status, 1'b1);
    release_all();

    // R3 threshold with early reversal
    rx_tone = 1'b1; step(1); rx_rev_pulse();
    ticks(DET_REV - 1);
    chk("R3 before threshold", tone_status, 1'b0);
    tick();
    chk("R3 at threshold", tone_status, 1'b1);
    release_all();

    // R4 gap resets duration (plain)
    std_sel = 1'b1; rx_tone = 1'b1;
    ticks(DET_PLN - 1);
    rx_tone = 1'b0; step(1); rx_tone = 1'b1;
    ticks(DET_PLN - 1);
    chk("R4 gap restarts duration", tone_status, 1'b0);
    tick();
    chk("R4 full stretch after gap", tone_status, 1'b1);
    release_all();

    // R4 gap discards remembered reversal
    std_sel = 1'b0; rx_tone = 1'b1; step(1); rx_rev_pulse();
    ticks(3);
    rx_tone = 1'b0; step(1); rx_tone = 1'b1;
    ticks(DET_REV);
    chk("R4 reversal forgotten", tone_status, 1'b0);
    rx_rev_pulse();
    chk("R4 new reversal detects", tone_status, 1'b1);
    release_all();

    // R6 reversal while tone absent is ignored
    std_sel = 1'b0; rx_tone = 1'b0; rx_rev_pulse();
    rx_tone = 1'b1; ticks(DET_REV);
    chk("R6 absent-tone reversal ignored", tone_status, 1'b0);
    rx_rev_pulse();
    chk("R6 valid reversal detects", tone_status, 1'b1);
    release_all();

    // R5 spacing sweep
    for (int g = 1; g <= 9; g++) begin
      std_sel = 1'b0; rx_tone = 1'b1; step(1);
      rx_rev_pulse();
      ticks(g);
      rx_rev_pulse();
      ticks(DET_REV - g);
      chk("R5 reversal spacing", tone_status, (g >= GAP_MIN) && (g <= GAP_MAX));
      release_all();
    end

    // R7 send path alone
    std_sel = 1'b1; tx_level = 6'd3; tx_tone = 1'b1;
    ticks(DET_PLN);
    chk("R7 send path detects", tone_status, 1'b1);
    rd();

    // R8 latch and release rules
    tx_tone = 1'b0; ticks(20);
    chk("R8 latched after tone loss", tone_status, 1'b1);
    rx_quiet = 1'b1; ticks(QUIET + 3);
    chk("R8 one path quiet holds", tone_status, 1'b1);
    tx_quiet = 1'b1; ticks(QUIET - 1);
    rx_quiet = 1'b0; step(1); rx_quiet = 1'b1;
    ticks(QUIET - 1);
    chk("R8 break restarts release", tone_status, 1'b1);
    chk("R8 irq quiet before release", irq_n, 1'b1);
    // R9 release edge coincides with read strobe
    tick_ms = 1'b1; @(negedge clk);
    tick_ms = 1'b0; status_rd = 1'b1; @(negedge clk);
    status_rd = 1'b0;
    chk("R8 released", tone_status, 1'b0);
    chk("R9 event wins over clear", irq_n, 1'b0);
    rx_quiet = 1'b0; tx_quiet = 1'b0;
    rd();
    chk("R9 cleared after read", irq_n, 1'b1);

    // R10 no progress without tick
    std_sel = 1'b1; rx_tone = 1'b1; rx_level = 6'd20;
    step(40);
    chk("R10 no tick no detect", tone_status, 1'b0);
    // R10 saturation past counter range
    ticks(14);
    chk("R10 detect", tone_status, 1'b1);
    rd();
    rx_quiet = 1'b1; tx_quiet = 1'b1;
    ticks(QUIET);
    rx_quiet = 1'b0; tx_quiet = 1'b0;
    step(2);
    chk("R10 saturated count re-detects", tone_status, 1'b1);
    chk("R10 irq after re-detect", irq_n, 1'b0);
    release_all();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule